// File: doc/BRIEF.md
# Multi-Channel Interprocessor Mailbox

This peripheral lets processors on a chip pass short fixed-size messages over a bank of one-way channels. Each channel keeps five things: an owner (the sender's one-hot vector), the set of destination vectors to interrupt, an interrupt mask, the pending destination bits, and an eight-word message buffer. A sender claims an idle channel by writing its own vector bit into the channel's owner register and reading it back. It then fills the message and destinations and fires the channel by writing its own bit to the send register. Every unmasked pending destination bit drives the matching line of a shared interrupt bus.

All channel registers are write-protected until a fixed key is written to a global lock register. Any other value written there locks the block again. A channel can complete in one of two ways. In automatic-acknowledge mode it completes one cycle after the send. In manual mode it completes once the receivers have cleared every pending bit. On completion the channel sets its acknowledge flag, becomes idle and releases its owner.

Top module: `ipc_mbox`

## Requirements
- R1: After reset every channel reads owner 0, mode 0x10 (idle set, acknowledge clear, automatic mode off) and mask 0xFFFFFFFF. `irq_o` is 0 and the lock register reads 1.
- R2: The lock register is at byte address 0xA00. It reads 0 once 0x1ACCE551 has been written to it. Writing any other value makes it read 1 again.
- R3: While the block is locked, writes to any channel register leave the channel unchanged.
- R4: Channel n's registers start at byte address n*0x40. Within a channel the offsets are: owner 0x00, destination 0x04, destination-clear 0x08, destination-status 0x0C, mode 0x10, mask 0x14, interrupt-clear 0x18, send 0x1C, and message word i at 0x20+4*i for i = 0..7. Message words read back the last value written.
- R5: A one-hot write to the owner register of an idle, unowned channel sets the owner. A write that is not one-hot, or that goes to a channel that is busy or already owned, is ignored.
- R6: A write to the destination register stores the value. A write to destination-clear clears the destination bits that are set in the written value.
- R7: A write to the send register of an idle, owned channel fires the channel only when the written value equals the owner. Firing ORs the destination bits into the pending bits and clears the idle bit (mode bit 4) and the acknowledge bit (mode bit 7). A send with any other value is ignored.
- R8: `irq_o[v]` is the OR over all channels of (pending[v] AND NOT mask[v]). Destination-status reads the channel's pending AND NOT mask.
- R9: A write to interrupt-clear clears the pending bits that are set in the written value.
- R10: With mode bit 0 set (automatic acknowledge), the channel reads busy in the cycle after a send. On the next edge it sets acknowledge, returns to idle and clears its owner, so mode then reads 0x91.
- R11: With mode bit 0 clear, a fired channel stays busy until its pending bits are all zero. On the following edge it sets acknowledge, returns to idle and clears its owner.
- R12: `bus_rdata` carries the addressed register one cycle after `bus_rd`. Addresses that map to no register read 0, and so do the write-only offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 32 | One interrupt line per processor vector |

## Verification
A lock state that does not track the key leaves channel registers frozen or open to writes, and the first read after a write shows it. A wrong owner or idle flag makes a later claim or send be dropped or accepted by mistake. That shows within two cycles as a missing interrupt line, or as the mode register reading busy when it should read 0x91. Pending or mask bits that are kept wrongly show on `irq_o` in the cycle after the send or clear that should have changed them, and destination-status shows the same fault through the bus.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam logic [11:0] LOCK_ADDR = 12'hA00;
  localparam int unsigned WIN_SHIFT = 6;

  // word slot inside one channel window
  localparam logic [3:0] SLOT_OWNER = 4'd0;
  localparam logic [3:0] SLOT_DST   = 4'd1;
  localparam logic [3:0] SLOT_DCLR  = 4'd2;
  localparam logic [3:0] SLOT_DSTAT = 4'd3;
  localparam logic [3:0] SLOT_MODE  = 4'd4;
  localparam logic [3:0] SLOT_MASK  = 4'd5;
  localparam logic [3:0] SLOT_ICLR  = 4'd6;
  localparam logic [3:0] SLOT_SEND  = 4'd7;

  localparam int unsigned MODE_AUTO_BIT = 0;
  localparam int unsigned MODE_IDLE_BIT = 4;
  localparam int unsigned MODE_ACK_BIT  = 7;

  function automatic logic is_onehot(input logic [WORD_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  function automatic logic [WORD_W-1:0] pack_mode(input logic auto_ack,
                                                  input logic idle,
                                                  input logic ack);
    logic [WORD_W-1:0] m;
    m = '0;
    m[MODE_AUTO_BIT] = auto_ack;
    m[MODE_IDLE_BIT] = idle;
    m[MODE_ACK_BIT]  = ack;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] visible_irq(input logic [WORD_W-1:0] pend,
                                                    input logic [WORD_W-1:0] mask);
    return pend & ~mask;
  endfunction

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned WIN_W = ADDR_W - WIN_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   ch_idx,
  output logic [3:0]        slot,
  output logic              ch_hit,
  output logic              lock_hit
);

  logic [WIN_W-1:0] win;

  assign win      = addr[ADDR_W-1:WIN_SHIFT];
  assign ch_idx   = addr[WIN_SHIFT+CH_W-1:WIN_SHIFT];
  assign slot     = addr[5:2];
  assign ch_hit   = (addr[1:0] == 2'b00) && (int'(win) < int'(NUM_CH));
  assign lock_hit = (addr == LOCK_ADDR[ADDR_W-1:0]);

endmodule

// File: rtl/ipc_mbox_lock.sv
module ipc_mbox_lock
  import ipc_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic              unlocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (wr_en) begin
      unlocked <= (wdata == UNLOCK_KEY);
    end
  end

endmodule

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned MSG_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        slot,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] irq_vec,
  output logic [WORD_W-1:0] owner_o,
  output logic              send_evt,
  output logic              idle_o,
  output logic              ack_o,
  output logic              auto_o
);

  logic [WORD_W-1:0] owner_q, dst_q, mask_q, pend_q;
  logic              auto_q, idle_q, ack_q, sent_q;
  logic [WORD_W-1:0] msg_q [MSG_WORDS];

  logic wr_owner, wr_dst, wr_dclr, wr_mode, wr_mask, wr_iclr, wr_send;
  logic claim_ok, auto_done, manual_done, done_evt;

  assign wr_owner = wr_en && (slot == SLOT_OWNER);
  assign wr_dst   = wr_en && (slot == SLOT_DST);
  assign wr_dclr  = wr_en && (slot == SLOT_DCLR);
  assign wr_mode  = wr_en && (slot == SLOT_MODE);
  assign wr_mask  = wr_en && (slot == SLOT_MASK);
  assign wr_iclr  = wr_en && (slot == SLOT_ICLR);
  assign wr_send  = wr_en && (slot == SLOT_SEND);

  assign claim_ok    = wr_owner && idle_q && (owner_q == '0) && is_onehot(wdata);
  assign send_evt    = wr_send && idle_q && (owner_q != '0) && (wdata == owner_q);
  assign auto_done   = sent_q && auto_q;
  assign manual_done = !idle_q && !auto_q && (pend_q == '0);
  assign done_evt    = auto_done || manual_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      dst_q   <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
      auto_q  <= 1'b0;
      idle_q  <= 1'b1;
      ack_q   <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      sent_q <= send_evt;
      if (claim_ok) begin
        owner_q <= wdata;
        ack_q   <= 1'b0;
      end
      if (done_evt) begin
        idle_q  <= 1'b1;
        ack_q   <= 1'b1;
        owner_q <= '0;
      end
      if (send_evt) begin
        idle_q <= 1'b0;
        ack_q  <= 1'b0;
        pend_q <= pend_q | dst_q;
      end
      if (wr_iclr) pend_q <= pend_q & ~wdata;
      if (wr_dst)  dst_q  <= wdata;
      if (wr_dclr) dst_q  <= dst_q & ~wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_mode) auto_q <= wdata[MODE_AUTO_BIT];
    end
  end

  for (genvar w = 0; w < MSG_WORDS; w++) begin : g_msg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msg_q[w] <= '0;
      end else if (wr_en && slot[3] && (slot[2:0] == 3'(w))) begin
        msg_q[w] <= wdata;
      end
    end
  end

  assign irq_vec = visible_irq(pend_q, mask_q);
  assign owner_o = owner_q;
  assign idle_o  = idle_q;
  assign ack_o   = ack_q;
  assign auto_o  = auto_q;

  always_comb begin
    rd_data = '0;
    if (slot[3]) begin
      if (int'(slot[2:0]) < int'(MSG_WORDS)) rd_data = msg_q[slot[2:0]];
    end else begin
      case (slot)
        SLOT_OWNER: rd_data = owner_q;
        SLOT_DST:   rd_data = dst_q;
        SLOT_DSTAT: rd_data = irq_vec;
        SLOT_MODE:  rd_data = pack_mode(auto_q, idle_q, ack_q);
        SLOT_MASK:  rd_data = mask_q;
        default:    rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NUM_CH    = 32,
  parameter int unsigned MSG_WORDS = 8,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] irq_o
);

  logic [CH_W-1:0] ch_idx;
  logic [3:0]      slot;
  logic            ch_hit, lock_hit, unlocked;

  logic [NUM_CH-1:0][WORD_W-1:0] ch_rd, ch_irq, ch_owner;
  logic [NUM_CH-1:0] send_vec, idle_vec, ack_vec, auto_vec;

  ipc_mbox_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr), .ch_idx(ch_idx), .slot(slot),
    .ch_hit(ch_hit), .lock_hit(lock_hit)
  );

  ipc_mbox_lock lock_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && lock_hit),
    .wdata(bus_wdata), .unlocked(unlocked)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_wr;
    assign sel_wr = bus_wr && unlocked && ch_hit && (ch_idx == CH_W'(g));
    ipc_mbox_chan #(.MSG_WORDS(MSG_WORDS)) chan_i (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .slot(slot),
      .wdata(bus_wdata), .rd_data(ch_rd[g]), .irq_vec(ch_irq[g]),
      .owner_o(ch_owner[g]), .send_evt(send_vec[g]), .idle_o(idle_vec[g]),
      .ack_o(ack_vec[g]), .auto_o(auto_vec[g])
    );
  end

  always_comb begin
    irq_o = '0;
    for (int i = 0; i < NUM_CH; i++) irq_o = irq_o | ch_irq[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (lock_hit)    bus_rdata <= {{(WORD_W-1){1'b0}}, ~unlocked};
      else if (ch_hit) bus_rdata <= ch_rd[ch_idx];
      else             bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end

endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr,
  input logic [WORD_W-1:0]             bus_wdata,
  input logic                          lock_hit,
  input logic                          ch_hit,
  input logic                          unlocked,
  input logic [NUM_CH-1:0][WORD_W-1:0] ch_owner,
  input logic [NUM_CH-1:0]             send_vec,
  input logic [NUM_CH-1:0]             idle_vec,
  input logic [NUM_CH-1:0]             ack_vec,
  input logic [NUM_CH-1:0]             auto_vec
);

  a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(bus_wr && lock_hit && (bus_wdata == UNLOCK_KEY)));

  a_r3_locked_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked && ch_hit) |=> ($stable(ch_owner) && $stable(idle_vec)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_owner[g]));

    a_r7_send_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      send_vec[g] |=> !idle_vec[g]);

    a_r10_auto_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (send_vec[g] && auto_vec[g]) |=> ##1 (idle_vec[g] && ack_vec[g] && (ch_owner[g] == '0)));
  end

endmodule

bind ipc_mbox ipc_mbox_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .lock_hit(lock_hit), .ch_hit(ch_hit), .unlocked(unlocked),
  .ch_owner(ch_owner), .send_vec(send_vec), .idle_vec(idle_vec),
  .ack_vec(ack_vec), .auto_vec(auto_vec)
);

// File: tb/ipc_mbox_tb.sv
`timescale 1ns/1ps
module ipc_mbox_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipc_mbox dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  localparam logic [11:0] LOCK_A = 12'hA00;
  localparam logic [31:0] KEY    = 32'h1ACCE551;

  function automatic logic [11:0] reg_a(input int ch, input int off);
    return 12'(ch * 64 + off);
  endfunction

  function automatic logic [31:0] exp_irq(input logic [31:0] pend, input logic [31:0] mask);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = pend[b] && !mask[b];
    return r;
  endfunction

  function automatic logic [31:0] exp_mode(input bit a, input bit idle, input bit ack);
    return (a ? 32'h1 : 32'h0) + (idle ? 32'h10 : 32'h0) + (ack ? 32'h80 : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq after reset", irq_o, 32'h0);
    rd_chk("R1 lock reads locked", LOCK_A, 32'h1);
    rd_chk("R1 mode idle", reg_a(0, 'h10), 32'h10);
    rd_chk("R1 mask all set", reg_a(31, 'h14), 32'hFFFF_FFFF);
    rd_chk("R1 owner empty", reg_a(9, 'h00), 32'h0);

    // R3 writes ignored while locked
    wr(reg_a(3, 'h00), 32'h4);
    wr(reg_a(3, 'h24), 32'hDEAD_BEEF);
    rd_chk("R3 locked owner write", reg_a(3, 'h00), 32'h0);
    rd_chk("R3 locked data write", reg_a(3, 'h24), 32'h0);

    // R2 key handling
    wr(LOCK_A, 32'h1ACC_E550);
    rd_chk("R2 wrong key", LOCK_A, 32'h1);
    wr(LOCK_A, KEY);
    rd_chk("R2 key unlocks", LOCK_A, 32'h0);

    // R4 message words and window placement, R12 unmapped
    for (int i = 0; i < 8; i++) wr(reg_a(5, 'h20 + 4 * i), 32'hA500_0000 + 32'(i));
    for (int i = 0; i < 8; i++) rd_chk("R4 message word", reg_a(5, 'h20 + 4 * i), 32'hA500_0000 + 32'(i));
    rd_chk("R4 neighbour window untouched", reg_a(6, 'h20), 32'h0);
    rd_chk("R12 unmapped address", 12'h900, 32'h0);
    rd_chk("R12 write-only offset", reg_a(5, 'h1C), 32'h0);

    // R5 claim
    wr(reg_a(2, 'h00), 32'h8);
    rd_chk("R5 claim read back", reg_a(2, 'h00), 32'h8);
    wr(reg_a(2, 'h00), 32'h10);
    rd_chk("R5 second claim ignored", reg_a(2, 'h00), 32'h8);
    wr(reg_a(4, 'h00), 32'h3);
    rd_chk("R5 multi-bit claim ignored", reg_a(4, 'h00), 32'h0);

    // R6 destination set and clear
    wr(reg_a(2, 'h04), 32'h00F0);
    wr(reg_a(2, 'h08), 32'h0030);
    rd_chk("R6 destination after clear", reg_a(2, 'h04), 32'h00C0);

    // R7/R8/R10 automatic send
    wr(reg_a(2, 'h14), ~32'h00C0);
    wr(reg_a(2, 'h10), 32'h1);
    wr(reg_a(2, 'h1C), 32'h10);
    check("R7 wrong-value send no irq", irq_o, 32'h0);
    rd_chk("R7 wrong-value send stays idle", reg_a(2, 'h10), 32'h11);
    wr(reg_a(2, 'h1C), 32'h8);
    check("R8 irq raised", irq_o, 32'h00C0);
    rd_chk("R7 busy after send", reg_a(2, 'h10), 32'h01);
    rd_chk("R10 auto ack idle", reg_a(2, 'h10), 32'h91);
    rd_chk("R10 owner released", reg_a(2, 'h00), 32'h0);
    rd_chk("R8 destination status", reg_a(2, 'h0C), 32'h00C0);

    // R9 interrupt clear
    wr(reg_a(2, 'h18), 32'h0040);
    check("R9 partial clear", irq_o, 32'h0080);
    wr(reg_a(2, 'h18), 32'h0080);
    check("R9 full clear", irq_o, 32'h0);

    // R11 manual completion
    wr(reg_a(7, 'h00), 32'h2);
    wr(reg_a(7, 'h04), 32'h3);
    wr(reg_a(7, 'h14), 32'h0);
    wr(reg_a(7, 'h10), 32'h0);
    wr(reg_a(7, 'h1C), 32'h2);
    check("R11 manual irq", irq_o, 32'h3);
    @(negedge clk);
    rd_chk("R11 busy while pending", reg_a(7, 'h10), 32'h00);
    wr(reg_a(7, 'h18), 32'h1);
    @(negedge clk);
    rd_chk("R11 still busy with one pending", reg_a(7, 'h10), 32'h00);
    wr(reg_a(7, 'h18), 32'h2);
    @(negedge clk);
    rd_chk("R11 completes when clear", reg_a(7, 'h10), 32'h90);
    rd_chk("R11 owner released", reg_a(7, 'h00), 32'h0);

    // R2 relock, R3 write ignored
    wr(LOCK_A, 32'h0);
    rd_chk("R2 relock", LOCK_A, 32'h1);
    wr(reg_a(7, 'h04), 32'hFF);
    rd_chk("R3 locked destination write", reg_a(7, 'h04), 32'h3);
    wr(LOCK_A, KEY);

    // random traffic: R8 R9 R10 R4
    for (int it = 0; it < 40; it++) begin
      int ch;
      int w;
      logic [31:0] s, dd, m, v;
      ch = int'($urandom_range(31, 0));
      s  = 32'h1 << $urandom_range(31, 0);
      dd = $urandom();
      m  = $urandom();
      w  = int'($urandom_range(7, 0));
      v  = $urandom();
      wr(reg_a(ch, 'h20 + 4 * w), v);
      rd_chk("R4 random message word", reg_a(ch, 'h20 + 4 * w), v);
      wr(reg_a(ch, 'h00), s);
      wr(reg_a(ch, 'h14), m);
      wr(reg_a(ch, 'h04), dd);
      wr(reg_a(ch, 'h10), 32'h1);
      wr(reg_a(ch, 'h1C), s);
      check("R8 random irq", irq_o, exp_irq(dd, m));
      rd_chk("R10 random busy", reg_a(ch, 'h10), exp_mode(1'b1, 1'b0, 1'b0));
      rd_chk("R8 random status", reg_a(ch, 'h0C), exp_irq(dd, m));
      rd_chk("R10 random complete", reg_a(ch, 'h10), exp_mode(1'b1, 1'b1, 1'b1));
      wr(reg_a(ch, 'h18), 32'hFFFF_FFFF);
      check("R9 random clear", irq_o, 32'h0);
    end

    rd(LOCK_A, d);
    check("R2 still unlocked", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired, run did not finish (all requirements)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule